// File: doc/BRIEF.md
# Single-Wire Pulse-Count Negative Rail Programmer

This block decodes one control line that carries three things at once: the enable for a display supply, a count of rising edges that selects the negative rail voltage, and a shutdown request. The three are told apart only by how long the line stays at each level. All timing is measured in clock cycles of a fixed system clock. The line is first passed through a synchronizer.

A rising edge on a disabled line turns the supply on and loads the default code 000000 (-4.0 V). This happens only if the line was low long enough beforehand. An initialization window follows, and edges inside it are ignored. After the window, each rising edge that closes a well-formed pulse adds one to a count. Once the line stays high for the store interval, the count is committed as a 6-bit code. Code N sets -5.4 V + (N-1) x 0.1 V, so code 41 sets -1.4 V. Holding the line low for the shutdown interval turns the supply off.

The state machine has four states:

- `ST_OFF`: the supply is disabled.
- `ST_INIT`: the initialization window, during which edges are ignored.
- `ST_IDLE`: enabled, with no count pending.
- `ST_COLLECT`: enabled, with at least one counted edge pending.

Its transitions are:

- wake: `ST_OFF` to `ST_INIT`.
- armed: `ST_INIT` to `ST_IDLE`.
- first count: `ST_IDLE` to `ST_COLLECT`.
- commit: `ST_COLLECT` to `ST_IDLE`.
- sleep: any enabled state to `ST_OFF`.

Top module: `negrail_pulse_prog`

## Requirements
- R1: While reset is asserted and after its release with the line low, `en_o` is 0, `code_o` is 0 and `code_vld_o` is 0.
- R2: A rise of `ctl_in` while disabled enables the supply if the line was low for at least `OFF_CYC` cycles, or if it has been low since reset. `en_o` goes to 1 after the third clock edge that sees the new level, and in that same cycle `code_o` becomes 0 and `code_vld_o` pulses.
- R3: While disabled, a rise that follows a low shorter than `OFF_CYC` cycles is ignored. `en_o` stays 0 and no strobe appears.
- R4: A rising edge that reaches the decoder within `INIT_CYC` cycles of the wake transition is not counted.
- R5: After the window, a rising edge is counted when two conditions hold: the low just before it lasted `PW_MIN_CYC` to `PW_MAX_CYC` cycles, and the high before that low lasted at least `PW_MIN_CYC` cycles. The pending count N is committed as code N when the line has stayed high for `STORE_CYC` cycles after the last counted edge. The new code appears together with the strobe, `STORE_CYC`+3 cycles after that edge is applied at the input.
- R6: A low shorter than `PW_MIN_CYC` or longer than `PW_MAX_CYC` (but shorter than `SDN_CYC`) does not count. A burst made only of such pulses commits nothing and leaves the code unchanged.
- R7: A high shorter than `PW_MIN_CYC` disqualifies the rising edge that ends the following low.
- R8: Counts above `CODE_MAX` (41) saturate, so the committed code never exceeds 41 (101001).
- R9: `code_vld_o` lasts exactly one cycle. `code_o` changes only in a strobe cycle. Every burst counts from zero.
- R10: A low lasting `SDN_CYC` cycles disables the supply. `en_o` falls `SDN_CYC`+3 cycles after the fall is applied, and `code_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_in | input | 1 | Asynchronous single-wire control line |
| en_o | output | 1 | Supply enable |
| code_o | output | CODE_W | Committed rail code |
| code_vld_o | output | 1 | One-cycle strobe when a code is committed |

## Verification
The bench counts the latency of each result from the cycle a level is first applied at `ctl_in`. That latency is two synchronizer flops plus the level register, so the wake appears after three edges, the commit after `STORE_CYC`+3 edges and the shutdown after `SDN_CYC`+3 edges. At each of these points the bench checks the output in the cycle just before the change, again in the change cycle, and then one cycle later for the strobe. All samples are taken on the falling clock edge. The main sweep covers every count from 1 to `CODE_MAX`+2 with varied pulse widths, and strobes are tallied on every sampled cycle. Between the sweep and shutdown, targeted bursts probe the width bounds, the short-high rule and the restart bound at exactly `OFF_CYC`-1 and `OFF_CYC`.

// File: rtl/negrail_pkg.sv
package negrail_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_INIT    = 2'd1,
        ST_IDLE    = 2'd2,
        ST_COLLECT = 2'd3
    } prog_state_e;

    function automatic int larger(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/negrail_sync.sv
module negrail_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = sr_q[STAGES-1];

    // R2: the decoder sees the input only after the full flop chain
    a_r2_sync_chain: assert property (@(posedge clk) disable iff (!rst_n)
        q_o == $past(sr_q[STAGES-2]));

endmodule

// File: rtl/negrail_runlen.sv
module negrail_runlen #(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    output logic             lvl_o,
    output logic [RUN_W-1:0] run_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic             lvl_q;
    logic [RUN_W-1:0] run_q;

    // run_q counts the samples the line has held lvl_q, saturating;
    // reset to saturated low so the first rise after reset may wake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '1;
        end else begin
            lvl_q <= line_i;
            if (line_i != lvl_q) begin
                run_q <= RUN_W'(1);
            end else if (run_q != '1) begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end

    assign lvl_o  = lvl_q;
    assign run_o  = run_q;
    assign rise_o = line_i & ~lvl_q;
    assign fall_o = ~line_i & lvl_q;

    // R5: each level change restarts the width measurement
    a_r5_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o || fall_o) |=> (run_q == RUN_W'(1)));

endmodule

// File: rtl/negrail_tally.sv
module negrail_tally #(
    parameter int CODE_W   = 6,
    parameter int CODE_MAX = 41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [CODE_W-1:0] cnt_o
);
    localparam logic [CODE_W-1:0] CAP = CODE_W'(CODE_MAX);

    logic [CODE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != CAP)) begin
            cnt_q <= cnt_q + CODE_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    // R8: the pending count never passes the top code
    a_r8_tally_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);

endmodule

// File: rtl/negrail_pulse_prog.sv
module negrail_pulse_prog #(
    parameter int SYNC_STAGES = 2,
    parameter int CODE_W      = 6,
    parameter int CODE_MAX    = 41,
    parameter int INIT_CYC    = 3500,
    parameter int PW_MIN_CYC  = 20,
    parameter int PW_MAX_CYC  = 250,
    parameter int STORE_CYC   = 550,
    parameter int SDN_CYC     = 550,
    parameter int OFF_CYC     = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_in,
    output logic              en_o,
    output logic [CODE_W-1:0] code_o,
    output logic              code_vld_o
);
    import negrail_pkg::*;

    localparam int RUN_LIMIT = larger(larger(OFF_CYC, SDN_CYC), larger(STORE_CYC, PW_MAX_CYC));
    localparam int RUN_W     = $clog2(RUN_LIMIT + 1);
    localparam int TCNT_W    = $clog2(INIT_CYC + 1);

    localparam logic [RUN_W-1:0]  PMIN_L    = RUN_W'(PW_MIN_CYC);
    localparam logic [RUN_W-1:0]  PMAX_L    = RUN_W'(PW_MAX_CYC);
    localparam logic [RUN_W-1:0]  STORE_L   = RUN_W'(STORE_CYC);
    localparam logic [RUN_W-1:0]  SDN_L     = RUN_W'(SDN_CYC);
    localparam logic [RUN_W-1:0]  OFF_L     = RUN_W'(OFF_CYC);
    localparam logic [TCNT_W-1:0] INIT_LAST = TCNT_W'(INIT_CYC - 1);

    // line conditioning and width measurement
    logic             line_s;
    logic             lvl_q;
    logic [RUN_W-1:0] run_q;
    logic             rise;
    logic             fall;

    negrail_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ctl_in),
        .q_o   (line_s)
    );

    negrail_runlen #(.RUN_W(RUN_W)) u_runlen (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_s),
        .lvl_o  (lvl_q),
        .run_o  (run_q),
        .rise_o (rise),
        .fall_o (fall)
    );

    // edge tally
    logic              tally_clr;
    logic              tally_inc;
    logic [CODE_W-1:0] tally_cnt;

    negrail_tally #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tally_clr),
        .inc_i (tally_inc),
        .cnt_o (tally_cnt)
    );

    // control state
    prog_state_e       state_q, state_d;
    logic [TCNT_W-1:0] tcnt_q;
    logic              hi_ok_q;
    logic [CODE_W-1:0] code_q;
    logic              vld_q;

    logic low_long, pulse_ok, store_due, init_done;
    logic ev_wake, ev_commit;

    always_comb begin
        low_long  = !lvl_q && (run_q >= SDN_L);
        pulse_ok  = rise && hi_ok_q && (run_q >= PMIN_L) && (run_q <= PMAX_L);
        store_due = lvl_q && (run_q >= STORE_L);
        init_done = (tcnt_q == INIT_LAST);

        state_d   = state_q;
        ev_wake   = 1'b0;
        ev_commit = 1'b0;
        tally_inc = 1'b0;

        unique case (state_q)
            ST_OFF: begin
                if (rise && (run_q >= OFF_L)) begin
                    state_d = ST_INIT;
                    ev_wake = 1'b1;
                end
            end
            ST_INIT: begin
                if (low_long) begin
                    state_d = ST_OFF;
                end else if (init_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (low_long) begin
                    state_d = ST_OFF;
                end else if (pulse_ok) begin
                    state_d   = ST_COLLECT;
                    tally_inc = 1'b1;
                end
            end
            ST_COLLECT: begin
                if (low_long) begin
                    state_d = ST_OFF;
                end else begin
                    tally_inc = pulse_ok;
                    if (store_due) begin
                        state_d   = ST_IDLE;
                        ev_commit = 1'b1;
                    end
                end
            end
            default: state_d = ST_OFF;
        endcase

        tally_clr = ev_wake || ev_commit;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // init window timer and previous-high qualifier
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q  <= '0;
            hi_ok_q <= 1'b0;
        end else begin
            if (ev_wake) begin
                tcnt_q <= '0;
            end else if ((state_q == ST_INIT) && !init_done) begin
                tcnt_q <= tcnt_q + TCNT_W'(1);
            end
            if (ev_wake) begin
                hi_ok_q <= 1'b1;
            end else if (fall) begin
                hi_ok_q <= (run_q >= PMIN_L);
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= ev_wake || ev_commit;
            if (ev_wake) begin
                code_q <= '0;
            end else if (ev_commit) begin
                code_q <= tally_cnt;
            end
        end
    end

    assign en_o       = (state_q != ST_OFF);
    assign code_o     = code_q;
    assign code_vld_o = vld_q;

    // R9: strobe is a single cycle
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |=> !code_vld_o);

    // R9: the code moves only together with the strobe
    a_r9_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != $past(code_o)) |-> code_vld_o);

    // R8: committed code stays within range
    a_r8_code_cap: assert property (@(posedge clk) disable iff (!rst_n)
        code_o <= CODE_W'(CODE_MAX));

    // R2: waking loads the default code with a strobe
    a_r2_wake_default: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o) |-> (code_vld_o && (code_o == '0)));

    // R10: disabling follows only a long low
    a_r10_sleep_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_o) |-> $past(!lvl_q && (run_q >= SDN_L)));

    // R4: nothing is tallied during the init window
    a_r4_no_count_init: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |=> (tally_cnt == '0));

endmodule

// File: tb/negrail_pulse_prog_bench.sv
module negrail_pulse_prog_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 6;
    localparam int CODE_MAX   = 41;
    localparam int INIT_CYC   = 16;
    localparam int PW_MIN     = 2;
    localparam int PW_MAX     = 6;
    localparam int STORE      = 10;
    localparam int SDN        = 12;
    localparam int OFF        = 20;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_in = 1'b0;
    logic              en_o;
    logic [CODE_W-1:0] code_o;
    logic              code_vld_o;

    int tests = 0;
    int fails = 0;
    int nstb = 0;
    int cur_code = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    negrail_pulse_prog #(
        .SYNC_STAGES (2),
        .CODE_W      (CODE_W),
        .CODE_MAX    (CODE_MAX),
        .INIT_CYC    (INIT_CYC),
        .PW_MIN_CYC  (PW_MIN),
        .PW_MAX_CYC  (PW_MAX),
        .STORE_CYC   (STORE),
        .SDN_CYC     (SDN),
        .OFF_CYC     (OFF)
    ) u_negrail_pulse_prog (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_in     (ctl_in),
        .en_o       (en_o),
        .code_o     (code_o),
        .code_vld_o (code_vld_o)
    );

    // drive a level for n clock edges; sample on each falling edge
    task automatic hold(input logic v, input int n);
        ctl_in = v;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            nstb += int'(code_vld_o);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int lo, input int hi);
        hold(1'b0, lo);
        hold(1'b1, hi);
    endtask

    // last low, then the store interval with checks around the commit
    task automatic seal(input int lo, input int exp, input string req);
        hold(1'b0, lo);
        hold(1'b1, STORE + 2);
        chk({req, " strobe before store"}, int'(code_vld_o), 0);
        chk({req, " code before store"}, int'(code_o), cur_code);
        hold(1'b1, 1);
        chk({req, " strobe at store"}, int'(code_vld_o), 1);
        chk({req, " code at store"}, int'(code_o), exp);
        cur_code = exp;
        hold(1'b1, 1);
        chk({req, " R9 strobe single"}, int'(code_vld_o), 0);
        hold(1'b1, 2);
    endtask

    task automatic wake_check(input string req);
        hold(1'b1, 2);
        chk({req, " enable before latency"}, int'(en_o), 0);
        hold(1'b1, 1);
        chk({req, " enable"}, int'(en_o), 1);
        chk({req, " default code"}, int'(code_o), 0);
        chk({req, " wake strobe"}, int'(code_vld_o), 1);
        cur_code = 0;
        hold(1'b1, 1);
        chk({req, " R9 wake strobe single"}, int'(code_vld_o), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected below %0d", WATCHDOG, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int s0;
        rst_n  = 1'b0;
        ctl_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 en in reset", int'(en_o), 0);
        chk("R1 code in reset", int'(code_o), 0);
        rst_n = 1'b1;
        hold(1'b0, 3);
        chk("R1 en after reset", int'(en_o), 0);
        chk("R1 strobe after reset", int'(code_vld_o), 0);

        // R2: first wake straight after reset
        wake_check("R2");

        // R4: a pulse inside the init window is ignored
        s0 = nstb;
        pulse(3, 30);
        chk("R4 no strobe for init pulse", nstb - s0, 0);
        chk("R4 code after init pulse", int'(code_o), 0);

        // R5 / R8: sweep every count with varied widths
        for (int n = 1; n <= CODE_MAX + 2; n++) begin
            int lo;
            int hi;
            lo = PW_MIN + (n % (PW_MAX - PW_MIN + 1));
            hi = PW_MIN + ((n * 3) % (PW_MAX - PW_MIN + 1));
            for (int i = 0; i < n - 1; i++) pulse(lo, hi);
            if (n > CODE_MAX) seal(lo, CODE_MAX, "R8 saturate");
            else seal(lo, n, "R5 count");
        end

        // R6: too-short and too-long lows are not counted
        pulse(PW_MIN, 4);
        pulse(PW_MIN - 1, 4);
        pulse(PW_MAX, 4);
        pulse(PW_MAX + 1, 4);
        seal(PW_MIN, 3, "R6 width bounds");

        // R7: a short high disqualifies the next edge
        pulse(3, 1);
        pulse(3, 4);
        pulse(3, 4);
        pulse(3, 4);
        seal(3, 4, "R7 short high");

        // R6: burst of only rejected pulses commits nothing
        s0 = nstb;
        pulse(1, 4);
        pulse(PW_MAX + 1, STORE + 6);
        chk("R6 no strobe for rejected burst", nstb - s0, 0);
        chk("R6 code held", int'(code_o), 4);

        // R10: long low disables
        hold(1'b0, SDN + 2);
        chk("R10 still enabled", int'(en_o), 1);
        hold(1'b0, 1);
        chk("R10 disabled", int'(en_o), 0);
        chk("R10 code kept", int'(code_o), 4);

        // R3: restart after OFF-1 low is refused
        hold(1'b0, OFF - 1 - (SDN + 3));
        s0 = nstb;
        hold(1'b1, 4);
        chk("R3 short off refused", int'(en_o), 0);
        chk("R3 no strobe", nstb - s0, 0);

        // R2: restart after exactly OFF low
        hold(1'b0, OFF);
        wake_check("R2 restart");

        // R9: fresh count after restart
        hold(1'b1, INIT_CYC + 4);
        for (int i = 0; i < 4; i++) pulse(4, 3);
        seal(4, 5, "R9 fresh count");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule